// File: doc/BRIEF.md
# Operand Stack with Register-Held Top

This block holds the operand stack of a 32-bit stack processor. The topmost operand sits in a register of its own, called the top. The operand beneath it, the next, is read without delay from a 64-word array at the position of a 6-bit stack pointer. Instruction decode and the ALU sit outside the block. Each issued operation supplies three things: a two-bit signed pointer step, a flag that saves the old top into the array, and the value the top takes next.

The save happens at the pointer position after the step. A push therefore uses step +1 with the save flag set, so the old top becomes the new next operand. A pop uses step −1, and the caller passes the current next operand in as the new top. If a step would move the pointer outside 0..63, the operation is discarded and a one-cycle error strobe is raised.

Top module: `eval_stack`

## Requirements
- R1: After reset the pointer is 0, the top is 0, the whole array is 0 (so next reads 0), and err is low.
- R2: The step field `step_code` is decoded as 2'b01 = +1, 2'b11 = −1, 2'b10 = 0 and 2'b00 = 0. On an accepted operation the pointer moves by that amount.
- R3: If pointer + step is below 0 or at least 64, `err` is high for the one cycle after that clock edge. In every other cycle it is low.
- R4: An operation that raises `err` leaves the pointer, the top and the array unchanged.
- R5: When `save_top` is set on an accepted operation, the old top is written to the array at the updated pointer. `next_word` then shows it, and entries at other positions keep their values.
- R6: An accepted operation loads `new_top` into the top, whatever the step.
- R7: While `op_valid` is low, the pointer, the top and the array hold their values, and `err` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Qualifies the operation for this cycle |
| step_code | input | 2 | Sign-magnitude pointer step (R2) |
| save_top | input | 1 | Writes the old top at the updated pointer |
| new_top | input | 32 | Next value of the top register |
| top_word | output | 32 | Current top of stack |
| next_word | output | 32 | Array entry at the current pointer |
| sp | output | 6 | Current stack pointer |
| err | output | 1 | One-cycle range-error strobe |

## Verification
A wrong pointer shows up on `sp` at once, in the cycle after the operation, and on `next_word` as a value from the wrong slot. A save that lands on the wrong slot stays hidden until a later pop brings that slot under the pointer. The bench therefore unwinds pushes with pops and reads back each saved word. A range check that is off by one shows up only at pointer 0 and pointer 63, so the bench fills the stack to 63 and drains it to 0 and probes one step past each end.

// File: rtl/eval_stack.sv
module eval_stack #(
  parameter int W     = 32,
  parameter int DEPTH = 64,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [1:0]    step_code,
  input  logic          save_top,
  input  logic [W-1:0]  new_top,
  output logic [W-1:0]  top_word,
  output logic [W-1:0]  next_word,
  output logic [PW-1:0] sp,
  output logic          err
);

  localparam logic [PW:0] LIMIT = DEPTH[PW:0];

  logic [W-1:0]  mem [DEPTH];
  logic [PW+1:0] step, sum;
  logic          out_of_range, commit;

  always_comb begin
    case (step_code)
      2'b01:   step = {{(PW+1){1'b0}}, 1'b1};
      2'b11:   step = '1;
      default: step = '0;
    endcase
  end

  assign sum          = {2'b00, sp} + step;
  assign out_of_range = sum[PW+1] | (sum[PW:0] >= LIMIT);
  assign commit       = op_valid & ~out_of_range;
  assign next_word    = mem[sp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp       <= '0;
      top_word <= '0;
      err      <= 1'b0;
    end else begin
      err <= op_valid & out_of_range;
      if (commit) begin
        sp       <= sum[PW-1:0];
        top_word <= new_top;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (commit && save_top) begin
      mem[sum[PW-1:0]] <= top_word;
    end
  end

endmodule

module eval_stack_chk #(
  parameter int W  = 32,
  parameter int PW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_valid,
  input logic [1:0]    step_code,
  input logic          save_top,
  input logic [W-1:0]  new_top,
  input logic [W-1:0]  top_word,
  input logic [W-1:0]  next_word,
  input logic [PW-1:0] sp,
  input logic          err
);

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> ($stable(sp) && $stable(top_word) && !err));

  p_hold_on_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> ($stable(sp) && $stable(top_word)));

  p_under_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && step_code == 2'b11 && sp == '0) |=> err);

  p_over_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && step_code == 2'b01 && sp == '1) |=> err);

  p_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && step_code == 2'b01 && sp != '1) |=> (sp == PW'($past(sp) + 1'b1)));

  p_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && step_code == 2'b11 && sp != '0) |=> (sp == PW'($past(sp) - 1'b1)));

  p_push_save_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && save_top && step_code == 2'b01 && sp != '1) |=> (next_word == $past(top_word)));

  p_load_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && step_code[1:0] == 2'b10) |=> (top_word == $past(new_top) && !err));

endmodule

bind eval_stack eval_stack_chk #(.W(W), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .step_code(step_code),
  .save_top(save_top), .new_top(new_top), .top_word(top_word),
  .next_word(next_word), .sp(sp), .err(err)
);

// File: tb/eval_stack_test.sv
module eval_stack_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [1:0]  step_code = 2'b00;
  logic        save_top = 1'b0;
  logic [31:0] new_top = '0;
  logic [31:0] top_word, next_word;
  logic [5:0]  sp;
  logic        err;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  eval_stack uut (.clk(clk), .rst_n(rst_n), .op_valid(op_valid), .step_code(step_code),
    .save_top(save_top), .new_top(new_top), .top_word(top_word),
    .next_word(next_word), .sp(sp), .err(err));

  // {valid, step, save, new_top, exp_top, exp_next, exp_sp, exp_err}
  localparam int NV = 10;
  localparam logic [106:0] VEC [NV] = '{
    {1'b1, 2'b01, 1'b1, 32'hA000_0001, 32'hA000_0001, 32'h0,          6'd1, 1'b0}, // R2 R5 R6
    {1'b1, 2'b01, 1'b1, 32'hA000_0002, 32'hA000_0002, 32'hA000_0001, 6'd2, 1'b0}, // R5
    {1'b1, 2'b01, 1'b1, 32'hA000_0003, 32'hA000_0003, 32'hA000_0002, 6'd3, 1'b0}, // R5
    {1'b1, 2'b11, 1'b0, 32'hA000_0002, 32'hA000_0002, 32'hA000_0001, 6'd2, 1'b0}, // R2 pop
    {1'b1, 2'b10, 1'b1, 32'hB000_0005, 32'hB000_0005, 32'hA000_0002, 6'd2, 1'b0}, // R2 zero, R5
    {1'b1, 2'b00, 1'b0, 32'hC000_0006, 32'hC000_0006, 32'hA000_0002, 6'd2, 1'b0}, // R2 R6
    {1'b1, 2'b11, 1'b0, 32'hD000_0007, 32'hD000_0007, 32'h0,          6'd1, 1'b0}, // R2
    {1'b1, 2'b11, 1'b0, 32'hE000_0008, 32'hE000_0008, 32'h0,          6'd0, 1'b0}, // R2
    {1'b1, 2'b11, 1'b1, 32'hF000_0009, 32'hE000_0008, 32'h0,          6'd0, 1'b1}, // R3 R4
    {1'b0, 2'b01, 1'b1, 32'h1234_5678, 32'hE000_0008, 32'h0,          6'd0, 1'b0}  // R7
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic v, input logic [1:0] s, input logic w, input logic [31:0] n);
    @(negedge clk);
    op_valid = v; step_code = s; save_top = w; new_top = n;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 sp", {26'd0, sp}, 32'd0);
    chk("R1 top", top_word, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 next", next_word, 32'd0);
    chk("R1 err", {31'd0, err}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i][106], VEC[i][105:104], VEC[i][103], VEC[i][102:71]);
      chk($sformatf("R2-R7 vec%0d top", i), top_word, VEC[i][70:39]);
      chk($sformatf("R5 vec%0d next", i), next_word, VEC[i][38:7]);
      chk($sformatf("R2 vec%0d sp", i), {26'd0, sp}, {26'd0, VEC[i][6:1]});
      chk($sformatf("R3 vec%0d err", i), {31'd0, err}, {31'd0, VEC[i][0]});
    end

    // Fill to the top of the array
    for (int k = 1; k <= 63; k++) issue(1'b1, 2'b01, 1'b1, 32'(k));
    chk("R2 full sp", {26'd0, sp}, 32'd63);
    chk("R5 full next", next_word, 32'd62);
    issue(1'b1, 2'b01, 1'b1, 32'hDEAD_0000);
    chk("R3 over err", {31'd0, err}, 32'd1);
    chk("R4 over sp", {26'd0, sp}, 32'd63);
    chk("R4 over top", top_word, 32'd63);
    chk("R4 over next", next_word, 32'd62);
    @(negedge clk);
    chk("R3 strobe one cycle", {31'd0, err}, 32'd0);
    issue(1'b1, 2'b10, 1'b1, 32'h0000_0099);
    chk("R5 save at 63", next_word, 32'd63);
    chk("R6 top at 63", top_word, 32'h99);
    chk("R3 no err at 63", {31'd0, err}, 32'd0);

    // Drain, checking saved words come back in order
    for (int k = 62; k >= 1; k--) begin
      issue(1'b1, 2'b11, 1'b0, 32'h0);
      if (k == 1) chk("R5 drain next", next_word, 32'hE000_0008);
      else        chk("R5 drain next", next_word, 32'(k - 1));
    end
    issue(1'b1, 2'b11, 1'b0, 32'h0);
    chk("R2 drained sp", {26'd0, sp}, 32'd0);

    // Reset mid-run
    issue(1'b1, 2'b01, 1'b1, 32'h5555_AAAA);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 rerst sp", {26'd0, sp}, 32'd0);
    chk("R1 rerst top", top_word, 32'd0);
    chk("R1 rerst next", next_word, 32'd0);
    rst_n = 1'b1;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule